// File: doc/BRIEF.md
# USB Low/Full-Speed Line Receiver

This block takes an already synchronised D+/D- pair and recovers the serial data behind it. It samples the bus four times per bit. Each time the line changes between J, K or SE0, it moves its sample point back to the middle of the bit. Each sampled bit time is classified as J, K, SE0 or SE1. The J/K polarity follows a speed-mode input.

The recovered symbols are decoded from NRZI and stripped of stuffed bits, then packed into bytes with the earliest bit in bit 0. The block hunts for the packet sync pattern and reports the start of a packet. It reports end-of-packet conditions, including a bare EOP seen between packets, which serves as the low-speed keep-alive. After an EOP has been reported, the report is held off until the line has rested in J long enough, or until a new packet starts. This lets a series of keep-alives each be seen once.

Top module: `usbrx_front`

## Requirements
- R1: With `low_speed_i`=0, D+ high and D- low is J and the reverse is K. With `low_speed_i`=1 the two are swapped. Both low is SE0 and both high is SE1.
- R2: A bit time with the same J/K state as the one before decodes as 1, and a change decodes as 0. Data bytes appear on `byte_o` with a one-cycle `byte_vld_o`, and the first data bit received sits in bit 0.
- R3: The sync pattern (seven 0s then a 1, i.e. byte value 0x80 when assembled LSB-first) pulses `sop_o` for one cycle. The sync pattern itself is never delivered as a data byte.
- R4: Inside a packet, the bit that follows six consecutive 1s is dropped when it is 0. The closing 1 of the sync counts toward that run.
- R5: A 1 where a stuffed 0 was due pulses `stuff_err_o` and abandons the packet. No further bytes are delivered until the next sync.
- R6: SE0 for at least two bit times followed by J is an end of packet. It closes the packet, and any partly assembled byte is discarded.
- R7: An end of packet detected while no packet is open pulses `keepalive_o` in the same cycle as `eop_o`.
- R8: Once `eop_o` has pulsed, further ends of packet are not reported until either a sync is seen or seven consecutive J bit times occur. The J that closes the EOP counts as the first of the seven.
- R9: A sampled SE1 silently abandons any open packet.
- R10: Sampling is realigned on every line change, so a packet starting at any clock phase relative to the idle sampling is decoded correctly.
- R11: While reset is asserted, all event outputs and `byte_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at four times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| dp_i | input | 1 | Synchronised D+ |
| dm_i | input | 1 | Synchronised D- |
| low_speed_i | input | 1 | 1 selects low-speed J/K polarity |
| byte_o | output | 8 | Last assembled data byte |
| byte_vld_o | output | 1 | One-cycle strobe for `byte_o` |
| sop_o | output | 1 | Start of packet pulse |
| eop_o | output | 1 | End of packet pulse (when armed) |
| keepalive_o | output | 1 | End of packet seen with no packet open |
| stuff_err_o | output | 1 | Bit stuffing violation pulse |

## Verification
The bench keeps the default parameters: four samples per bit, a two-bit EOP minimum, a seven-bit re-arm window and a run of six. With these values the re-arm boundary sits between five and six idle bits after an EOP, so a directed pair of keep-alives can hit both sides of it. The bench offsets each packet by one to seven clocks before its sync, which covers every sample phase the realignment must recover from. Bytes of 0xFF force stuffed bits that cross byte borders.

// File: rtl/usbrx_pkg.sv
package usbrx_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] SYNC_VAL = 8'h80;

  typedef enum logic [1:0] {
    LN_SE0 = 2'd0,
    LN_J   = 2'd1,
    LN_K   = 2'd2,
    LN_SE1 = 2'd3
  } line_t;

  // Map the pin pair to a line state; low speed swaps J and K.
  function automatic line_t line_classify(input logic dp, input logic dm, input logic ls);
    case ({dp, dm})
      2'b00:   return LN_SE0;
      2'b11:   return LN_SE1;
      2'b10:   return ls ? LN_K : LN_J;
      default: return ls ? LN_J : LN_K;
    endcase
  endfunction

  // NRZI: unchanged state is a 1, a change is a 0.
  function automatic logic nrzi_bit(input line_t prev, input line_t cur);
    return prev == cur;
  endfunction
endpackage

// File: rtl/usbrx_sampler.sv
module usbrx_sampler import usbrx_pkg::*; #(
  parameter int OVERSAMPLE = 4
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dp_i,
  input  logic  dm_i,
  input  logic  low_speed_i,
  output logic  sym_stb,
  output line_t sym
);
  localparam int PW = $clog2(OVERSAMPLE);
  localparam logic [PW-1:0] MID    = PW'(OVERSAMPLE / 2);
  localparam logic [PW-1:0] MID_M1 = PW'(OVERSAMPLE / 2 - 1);
  localparam logic [PW-1:0] LAST   = PW'(OVERSAMPLE - 1);

  line_t lin, lst_q;
  logic [PW-1:0] ph_q;

  assign lin = line_classify(dp_i, dm_i, low_speed_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lst_q <= LN_J;
      ph_q  <= '0;
    end else begin
      lst_q <= lin;
      if (lin != lst_q)    ph_q <= PW'(1);
      else if (ph_q == LAST) ph_q <= '0;
      else                 ph_q <= ph_q + 1'b1;
    end
  end

  assign sym_stb = (ph_q == MID);
  assign sym     = lst_q;

  // R10
  resync_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == MID_M1 && lin == lst_q) |=> sym_stb);

  // R1
  j_polarity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_stb && sym == LN_J) |-> $past(low_speed_i ? (dm_i && !dp_i) : (dp_i && !dm_i)));
endmodule

// File: rtl/usbrx_nrzi.sv
module usbrx_nrzi import usbrx_pkg::*; #(
  parameter int EOP_BITS  = 2,
  parameter int IDLE_BITS = 7
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sym_stb,
  input  line_t sym,
  output logic  bit_vld,
  output logic  bit_val,
  output logic  eop_ev,
  output logic  lerr_ev,
  output logic  rearm_ev
);
  localparam int SW = $clog2(EOP_BITS + 1);
  localparam int JW = $clog2(IDLE_BITS + 1);
  localparam logic [SW-1:0] SE0_SAT = SW'(EOP_BITS);
  localparam logic [JW-1:0] J_SAT   = JW'(IDLE_BITS);
  localparam logic [JW-1:0] J_HIT   = JW'(IDLE_BITS - 1);

  line_t prev_q;
  logic [SW-1:0] se0_q;
  logic [JW-1:0] jrun_q;

  always_comb begin
    bit_vld  = 1'b0;
    bit_val  = 1'b0;
    eop_ev   = 1'b0;
    lerr_ev  = 1'b0;
    rearm_ev = sym_stb && (sym == LN_J) && (jrun_q == J_HIT);
    if (sym_stb) begin
      case (sym)
        LN_SE1: lerr_ev = 1'b1;
        LN_SE0: ;
        default: begin
          if (se0_q != '0) begin
            if (se0_q >= SE0_SAT && sym == LN_J) eop_ev = 1'b1;
            else                                 lerr_ev = 1'b1;
          end else begin
            bit_vld = 1'b1;
            bit_val = nrzi_bit(prev_q, sym);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= LN_J;
      se0_q  <= '0;
      jrun_q <= '0;
    end else if (sym_stb) begin
      case (sym)
        LN_SE1: begin
          prev_q <= LN_J;
          se0_q  <= '0;
          jrun_q <= '0;
        end
        LN_SE0: begin
          if (se0_q != SE0_SAT) se0_q <= se0_q + 1'b1;
          jrun_q <= '0;
        end
        default: begin
          prev_q <= sym;
          se0_q  <= '0;
          if (sym == LN_J) jrun_q <= (jrun_q == J_SAT) ? jrun_q : jrun_q + 1'b1;
          else             jrun_q <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/usbrx_framer.sv
module usbrx_framer import usbrx_pkg::*; #(
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_vld,
  input  logic              bit_val,
  input  logic              eop_ev,
  input  logic              lerr_ev,
  input  logic              rearm_ev,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_vld_o,
  output logic              sop_o,
  output logic              eop_o,
  output logic              keepalive_o,
  output logic              stuff_err_o
);
  localparam int RW = $clog2(STUFF_RUN + 1);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_RUN);
  localparam logic [CW-1:0] CNT_LAST = CW'(BYTE_W - 1);

  logic              in_pkt_q, armed_q;
  logic [BYTE_W-1:0] hunt_q, sh_q, hunt_nx, sh_nx;
  logic [CW-1:0]     cnt_q;
  logic [RW-1:0]     run_q;

  assign hunt_nx = {bit_val, hunt_q[BYTE_W-1:1]};
  assign sh_nx   = {bit_val, sh_q[BYTE_W-1:1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_pkt_q <= 1'b0;  armed_q <= 1'b1;
      hunt_q <= '1;  sh_q <= '0;  cnt_q <= '0;  run_q <= '0;
      byte_o <= '0;  byte_vld_o <= 1'b0;  sop_o <= 1'b0;
      eop_o <= 1'b0; keepalive_o <= 1'b0;  stuff_err_o <= 1'b0;
    end else begin
      byte_vld_o <= 1'b0;  sop_o <= 1'b0;  eop_o <= 1'b0;
      keepalive_o <= 1'b0; stuff_err_o <= 1'b0;
      if (rearm_ev) armed_q <= 1'b1;
      if (lerr_ev) begin
        in_pkt_q <= 1'b0;
        hunt_q   <= '1;
      end else if (eop_ev) begin
        if (armed_q) begin
          eop_o       <= 1'b1;
          keepalive_o <= !in_pkt_q;
          armed_q     <= 1'b0;
        end
        in_pkt_q <= 1'b0;
        hunt_q   <= '1;
      end else if (bit_vld) begin
        if (!in_pkt_q) begin
          hunt_q <= hunt_nx;
          if (hunt_nx == SYNC_VAL) begin
            sop_o    <= 1'b1;
            in_pkt_q <= 1'b1;
            armed_q  <= 1'b1;
            cnt_q    <= '0;
            run_q    <= RW'(1);
          end
        end else if (run_q == RUN_MAX) begin
          run_q <= '0;
          if (bit_val) begin
            stuff_err_o <= 1'b1;
            in_pkt_q    <= 1'b0;
            hunt_q      <= '1;
          end
        end else begin
          sh_q  <= sh_nx;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) begin
            byte_o     <= sh_nx;
            byte_vld_o <= 1'b1;
          end
          run_q <= bit_val ? run_q + 1'b1 : '0;
        end
      end
    end
  end

  // R3
  sop_opens_chk: assert property (@(posedge clk) disable iff (!rst_n) sop_o |-> in_pkt_q);
  // R2
  byte_in_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n) byte_vld_o |-> in_pkt_q);
  // R5
  stuff_abort_chk: assert property (@(posedge clk) disable iff (!rst_n) stuff_err_o |-> !in_pkt_q);
  // R7
  keepalive_eop_chk: assert property (@(posedge clk) disable iff (!rst_n) keepalive_o |-> eop_o);
  // R8
  eop_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n) eop_o |-> !armed_q);
endmodule

// File: rtl/usbrx_front.sv
module usbrx_front import usbrx_pkg::*; #(
  parameter int OVERSAMPLE      = 4,
  parameter int EOP_MIN_BITS    = 2,
  parameter int IDLE_REARM_BITS = 7,
  parameter int STUFF_RUN       = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dp_i,
  input  logic       dm_i,
  input  logic       low_speed_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       sop_o,
  output logic       eop_o,
  output logic       keepalive_o,
  output logic       stuff_err_o
);
  logic  sym_stb, bit_vld, bit_val, eop_ev, lerr_ev, rearm_ev;
  line_t sym;

  usbrx_sampler #(.OVERSAMPLE(OVERSAMPLE)) samp_i (
    .clk(clk), .rst_n(rst_n), .dp_i(dp_i), .dm_i(dm_i),
    .low_speed_i(low_speed_i), .sym_stb(sym_stb), .sym(sym)
  );

  usbrx_nrzi #(.EOP_BITS(EOP_MIN_BITS), .IDLE_BITS(IDLE_REARM_BITS)) nrzi_i (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym(sym),
    .bit_vld(bit_vld), .bit_val(bit_val), .eop_ev(eop_ev),
    .lerr_ev(lerr_ev), .rearm_ev(rearm_ev)
  );

  usbrx_framer #(.STUFF_RUN(STUFF_RUN)) frm_i (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .bit_val(bit_val),
    .eop_ev(eop_ev), .lerr_ev(lerr_ev), .rearm_ev(rearm_ev),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .sop_o(sop_o),
    .eop_o(eop_o), .keepalive_o(keepalive_o), .stuff_err_o(stuff_err_o)
  );
endmodule

// File: tb/usbrx_front_tb_top.sv
module usbrx_front_tb_top;
  localparam int OS = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic dp = 1'b1, dm = 1'b0, ls = 1'b0;
  logic [7:0] byte_o;
  logic byte_vld_o, sop_o, eop_o, keepalive_o, stuff_err_o;

  always #4 clk = ~clk;

  usbrx_front dut_i (
    .clk(clk), .rst_n(rst_n), .dp_i(dp), .dm_i(dm), .low_speed_i(ls),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .sop_o(sop_o), .eop_o(eop_o),
    .keepalive_o(keepalive_o), .stuff_err_o(stuff_err_o)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] rx_log [0:255];
  logic [7:0] tx_log [0:255];
  int rx_n = 0, tx_n = 0;
  int n_sop = 0, n_eop = 0, n_ka = 0, n_serr = 0;
  int e_sop = 0, e_eop = 0, e_ka = 0, e_serr = 0;
  int cur = 1;   // 1 = J, 2 = K
  int run = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_vld_o) begin rx_log[rx_n % 256] <= byte_o; rx_n <= rx_n + 1; end
      if (sop_o) n_sop <= n_sop + 1;
      if (eop_o) n_eop <= n_eop + 1;
      if (keepalive_o) n_ka <= n_ka + 1;
      if (stuff_err_o) n_serr <= n_serr + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Pin levels for a symbol under the current speed mode.
  function automatic logic [1:0] pins_for(input int s, input logic lsm);
    case (s)
      0: return 2'b00;
      3: return 2'b11;
      1: return lsm ? 2'b01 : 2'b10;
      default: return lsm ? 2'b10 : 2'b01;
    endcase
  endfunction

  task automatic put_sym(input int s);
    {dp, dm} = pins_for(s, ls);
    repeat (OS) @(negedge clk);
  endtask

  task automatic put_bit(input bit b);
    if (!b) cur = (cur == 1) ? 2 : 1;
    put_sym(cur);
  endtask

  task automatic send_sync();
    cur = 1;
    for (int i = 0; i < 7; i++) put_bit(1'b0);
    put_bit(1'b1);
    run = 1;
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) begin
      put_bit(v[i]);
      run = v[i] ? run + 1 : 0;
      if (run == 6) begin put_bit(1'b0); run = 0; end
    end
    tx_log[tx_n % 256] = v;
    tx_n++;
  endtask

  task automatic send_eop();
    put_sym(0); put_sym(0);
    cur = 1; put_sym(1);
  endtask

  task automatic idle(input int n);
    cur = 1;
    repeat (n) put_sym(1);
  endtask

  task automatic idle_clk(input int n);
    cur = 1;
    {dp, dm} = pins_for(1, ls);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_mode(input logic m);
    ls = m;
    {dp, dm} = pins_for(1, m);
    @(negedge clk);
  endtask

  task automatic check_events(input string req);
    check({req, " sop count"}, n_sop, e_sop);
    check({req, " eop count"}, n_eop, e_eop);
    check({req, " keepalive count"}, n_ka, e_ka);
    check({req, " stuff error count"}, n_serr, e_serr);
    check({req, " byte count"}, rx_n, tx_n);
  endtask

  task automatic check_bytes(input string req, input int from);
    for (int i = from; i < tx_n && i < rx_n; i++)
      check(req, int'(rx_log[i % 256]), int'(tx_log[i % 256]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int base;
    int len;
    logic [7:0] v;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // R11 reset state
    check("R11 outputs in reset", int'({byte_o, byte_vld_o, sop_o, eop_o, keepalive_o, stuff_err_o}), 0);
    rst_n = 1'b1;
    idle(10);

    // R4 full speed, runs of ones crossing byte borders
    base = tx_n;
    send_sync(); send_byte(8'hFF); send_byte(8'hFF); send_byte(8'h3F); send_eop(); idle(10);
    e_sop++; e_eop++;
    check_events("R4 stuffed FS packet");
    check_bytes("R4 stuffed byte value", base);

    // R1 low speed polarity
    set_mode(1'b1); idle(10);
    base = tx_n;
    send_sync(); send_byte(8'hA5); send_byte(8'h01); send_eop(); idle(10);
    e_sop++; e_eop++;
    check_events("R1 LS packet");
    check_bytes("R1 LS byte value", base);

    // R7 keep-alive, re-armed by long idle
    send_eop(); idle(10); send_eop(); idle(10);
    e_eop += 2; e_ka += 2;
    check_events("R7 keep-alives");

    // R8 boundary: 1+5 J bits is too short, 1+6 re-arms
    send_eop(); idle(5); send_eop(); idle(6); send_eop(); idle(10);
    e_eop += 2; e_ka += 2;
    check_events("R8 re-arm window");

    // R5 stuffing violation
    send_sync(); repeat (6) put_bit(1'b1); send_eop(); idle(10);
    e_sop++; e_serr++; e_eop++; e_ka++;
    check_events("R5 stuff violation");

    // R9 SE1 abort
    base = tx_n;
    send_sync(); send_byte(8'h5A); put_sym(3); idle(8);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b0); idle(2);
    send_eop(); idle(10);
    e_sop++; e_eop++; e_ka++;
    check_events("R9 SE1 abort");
    check_bytes("R9 byte before abort", base);

    // R6 partial byte discarded at EOP
    set_mode(1'b0); idle(10);
    base = tx_n;
    send_sync(); send_byte(8'hC3); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); send_eop(); idle(10);
    e_sop++; e_eop++;
    check_events("R6 partial byte");
    check_bytes("R6 whole byte", base);

    // R10 / R2 / R3 random packets at varied phase and mode
    for (int p = 0; p < 24; p++) begin
      set_mode(1'($urandom % 2));
      idle(8);
      idle_clk(1 + $urandom % 7);
      base = tx_n;
      len = 1 + $urandom % 6;
      send_sync();
      for (int b = 0; b < len; b++) begin
        v = ($urandom % 4 == 0) ? 8'hFF : 8'($urandom);
        send_byte(v);
      end
      send_eop(); idle(9);
      e_sop++; e_eop++;
      check("R3 sop per packet", n_sop, e_sop);
      check("R10 byte count at random phase", rx_n, tx_n);
      check_bytes("R2 byte value", base);
    end
    check_events("R2 final totals");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule